// File: doc/BRIEF.md
# Memory Error Injection Matcher

This block sits next to the write path of a memory controller and corrupts check data on purpose, so that the error handling that follows can be tested. Software programs it through a small register port. Six address fields can be matched, and each one has its own wildcard. The fields are DIMM slot within the channel, rank, channel, bank, page and column. Further registers hold a check-bit flip mask, a half-select, a type word and an arm control. All of these registers can be read back.

While the block is armed, a write access that matches every non-wildcard field produces a one-cycle strobe. The strobe comes with an XOR mask for the check bits and a parity-flip flag. The XOR mask is applied by the downstream ECC encoder. A one-shot setting disarms the block after its first hit. A repeat setting keeps it armed until software clears the arm control.

Top module: `mem_err_inject`

## Requirements
- R1: After a synchronous active-low reset, every field register has its wildcard flag set and value zero. The block is disarmed, and the type, half-select and flip-mask registers read zero. All injection outputs are low.
- R2: Register addresses: 0 is arm, 1 is type, 2 is half-select and 3 is flip mask. Addresses 8 to 13 are the fields in the order DIMM, rank, channel, bank, page, column. A field register holds its value in bits [MAXW-1:0] and its wildcard flag in bit 31. Every register reads back what was last written to its implemented bits.
- R3: Writing any nonzero value to the arm register arms the block, and writing zero disarms it. Bit 0 of the arm register reads 1 while the block is armed.
- R4: An injection happens only for an access with acc_valid=1 and acc_write=1 while the block is armed. Every field whose wildcard flag is clear must equal the access's value. Read accesses and accesses with a mismatching field never inject.
- R5: A field with its wildcard flag set matches every access value. A field with the flag clear matches only its exact value, including the value zero.
- R6: inj_strobe goes high for exactly one cycle, in the cycle after each injecting access. Back-to-back injecting accesses give back-to-back strobes.
- R7: The half-select controls which half of the check bits is corrupted. With value 0 no half is corrupted. With 1 inj_mask carries the flip mask in the lower half. With 2 it carries the upper half, and with 3 it carries both. Unselected halves of inj_mask are always zero.
- R8: The type register has three bits. Bit 1 enables the check-bit mask: when it is clear, inj_mask stays zero. Bit 2 raises inj_parity together with the strobe. Bit 0 selects repeat.
- R9: With type bit 0 clear, the first injection disarms the block, and later matching writes do not inject.
- R10: With type bit 0 set, the block stays armed and injects on every matching write until software writes zero to the arm register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_waddr | input | 4 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | 4 | Register read address |
| cfg_rdata | output | 32 | Register read data (combinational) |
| acc_valid | input | 1 | Access present on the write path |
| acc_write | input | 1 | Access is a write |
| acc_dimm | input | DIMM_W | DIMM slot within its channel |
| acc_rank | input | RANK_W | Rank |
| acc_chan | input | CHAN_W | Channel |
| acc_bank | input | BANK_W | Bank |
| acc_page | input | PAGE_W | Page (row) |
| acc_col | input | COL_W | Column |
| inj_strobe | output | 1 | One-cycle injection pulse |
| inj_mask | output | ECC_W | XOR mask for the check bits |
| inj_parity | output | 1 | Parity flip request |

## Verification
The hardest situation to reach is a one-shot that must stay quiet: after the first hit, an identical matching write must not inject. A real memory controller would rarely issue such a write soon enough to show a disarm bug. The bench sends two identical matching writes on consecutive cycles, so a lost disarm shows up as a second strobe. It then reads the arm register back. Exact matching of the value zero is driven with a non-wildcard DIMM field of 0 next to a write to slot 3. All six fields are also set non-wildcard at once, and one column bit is perturbed.

// File: rtl/einj_pkg.sv
// einj_pkg: shared constants for the error injection matcher.
// Assumes a 4-bit register address space and 32-bit register data.
package einj_pkg;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 32;
    localparam int WILD_BIT  = 31;
    localparam int NUM_FLD   = 6;
    localparam int FLD_BASE  = 8;
    localparam int TYPE_W    = 3;
    localparam int TB_REPEAT = 0;
    localparam int TB_ECC    = 1;
    localparam int TB_PAR    = 2;
    localparam logic [ADDR_W-1:0] A_ARM  = 4'h0;
    localparam logic [ADDR_W-1:0] A_TYPE = 4'h1;
    localparam logic [ADDR_W-1:0] A_SECT = 4'h2;
    localparam logic [ADDR_W-1:0] A_MASK = 4'h3;
endpackage

// File: rtl/einj_cfg_regs.sv
// einj_cfg_regs: register file of the injection matcher.
// Holds the arm state, type, half-select, flip mask and six field registers
// (value + separate wildcard flag). A one-shot hit clears the arm state; a
// software write to the arm register in the same cycle takes precedence.
// Assumes MAXW <= 31 and ECC_W <= 32.
module einj_cfg_regs
    import einj_pkg::*;
#(
    parameter int NF    = NUM_FLD,
    parameter int MAXW  = 16,
    parameter int ECC_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    input  logic                 hit,
    output logic                 armed,
    output logic                 ecc_on,
    output logic                 par_on,
    output logic [1:0]           sect,
    output logic [ECC_W-1:0]     ecc_mask,
    output logic [NF*MAXW-1:0]   fld_val,
    output logic [NF-1:0]        fld_wild
);
    logic [MAXW-1:0]   val_q [NF];
    logic [NF-1:0]     wild_q;
    logic              armed_q;
    logic [TYPE_W-1:0] typ_q;
    logic [1:0]        sect_q;
    logic [ECC_W-1:0]  ecc_q;
    logic              arm_wr;

    // Software access to the arm register
    assign arm_wr = wr_en && (wr_addr == A_ARM);

    // Register updates: reset to wildcard/disarmed, one-shot clear, writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NF; i++) val_q[i] <= '0;
            wild_q  <= '1;
            armed_q <= 1'b0;
            typ_q   <= '0;
            sect_q  <= '0;
            ecc_q   <= '0;
        end else begin
            if (hit && !typ_q[TB_REPEAT]) armed_q <= 1'b0;
            if (arm_wr) armed_q <= |wr_data;
            if (wr_en) begin
                if (wr_addr == A_TYPE) typ_q  <= wr_data[TYPE_W-1:0];
                if (wr_addr == A_SECT) sect_q <= wr_data[1:0];
                if (wr_addr == A_MASK) ecc_q  <= wr_data[ECC_W-1:0];
                for (int i = 0; i < NF; i++) begin
                    if (wr_addr == ADDR_W'(FLD_BASE + i)) begin
                        val_q[i]  <= wr_data[MAXW-1:0];
                        wild_q[i] <= wr_data[WILD_BIT];
                    end
                end
            end
        end
    end

    // Combinational readback of every register
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_ARM:   rd_data[0]            = armed_q;
            A_TYPE:  rd_data[TYPE_W-1:0]   = typ_q;
            A_SECT:  rd_data[1:0]          = sect_q;
            A_MASK:  rd_data[ECC_W-1:0]    = ecc_q;
            default: rd_data               = '0;
        endcase
        for (int i = 0; i < NF; i++) begin
            if (rd_addr == ADDR_W'(FLD_BASE + i)) begin
                rd_data[MAXW-1:0] = val_q[i];
                rd_data[WILD_BIT] = wild_q[i];
            end
        end
    end

    // Flatten field values for the comparators
    always_comb begin
        for (int i = 0; i < NF; i++) fld_val[i*MAXW +: MAXW] = val_q[i];
    end

    assign fld_wild = wild_q;
    assign armed    = armed_q;
    assign ecc_on   = typ_q[TB_ECC];
    assign par_on   = typ_q[TB_PAR];
    assign sect     = sect_q;
    assign ecc_mask = ecc_q;

    // R9
    oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !typ_q[TB_REPEAT] && !arm_wr) |=> !armed_q);
    // R10
    repeat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && typ_q[TB_REPEAT] && !arm_wr) |=> armed_q);
    // R3
    arm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_wr && (|wr_data)) |=> armed_q);
endmodule

// File: rtl/einj_field_match.sv
// einj_field_match: compares one address field against its programmed value.
// The field occupies the low W bits of a MAXW-wide lane; bits above W are
// ignored. A set wildcard flag forces a match.
module einj_field_match #(
    parameter int MAXW = 16,
    parameter int W    = 2
) (
    input  logic [MAXW-1:0] cfg_val,
    input  logic            wild,
    input  logic [MAXW-1:0] acc_val,
    output logic            match
);
    localparam logic [MAXW-1:0] FMASK = MAXW'((64'd1 << W) - 64'd1);

    // Masked equality or wildcard
    always_comb begin
        match = wild || (((cfg_val ^ acc_val) & FMASK) == '0);
    end
endmodule

// File: rtl/mem_err_inject.sv
// mem_err_inject: matches write accesses against six programmable address
// fields and, when armed, emits a registered one-cycle strobe together with a
// check-bit XOR mask (half-selected) and a parity flip flag.
// Assumes ECC_W is even and every field width is at most 31 bits.
module mem_err_inject
    import einj_pkg::*;
#(
    parameter int DIMM_W = 2,
    parameter int RANK_W = 2,
    parameter int CHAN_W = 2,
    parameter int BANK_W = 3,
    parameter int PAGE_W = 16,
    parameter int COL_W  = 11,
    parameter int ECC_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_waddr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    input  logic [ADDR_W-1:0]  cfg_raddr,
    output logic [DATA_W-1:0]  cfg_rdata,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [DIMM_W-1:0]  acc_dimm,
    input  logic [RANK_W-1:0]  acc_rank,
    input  logic [CHAN_W-1:0]  acc_chan,
    input  logic [BANK_W-1:0]  acc_bank,
    input  logic [PAGE_W-1:0]  acc_page,
    input  logic [COL_W-1:0]   acc_col,
    output logic               inj_strobe,
    output logic [ECC_W-1:0]   inj_mask,
    output logic               inj_parity
);
    function automatic int fld_w(int i);
        case (i)
            0: return DIMM_W;
            1: return RANK_W;
            2: return CHAN_W;
            3: return BANK_W;
            4: return PAGE_W;
            default: return COL_W;
        endcase
    endfunction

    function automatic int max_w();
        int m = 1;
        for (int i = 0; i < NUM_FLD; i++) if (fld_w(i) > m) m = fld_w(i);
        return m;
    endfunction

    localparam int MAXW = max_w();
    localparam int HALF = ECC_W / 2;

    logic [NUM_FLD*MAXW-1:0] fld_val;
    logic [NUM_FLD*MAXW-1:0] acc_lane;
    logic [NUM_FLD-1:0]      fld_wild;
    logic [NUM_FLD-1:0]      fld_hit;
    logic                    armed, ecc_on, par_on, hit;
    logic [1:0]              sect;
    logic [ECC_W-1:0]        ecc_mask, half_mask;

    einj_cfg_regs #(.NF(NUM_FLD), .MAXW(MAXW), .ECC_W(ECC_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_addr(cfg_waddr), .wr_data(cfg_wdata),
        .rd_addr(cfg_raddr), .rd_data(cfg_rdata),
        .hit(hit), .armed(armed), .ecc_on(ecc_on), .par_on(par_on),
        .sect(sect), .ecc_mask(ecc_mask),
        .fld_val(fld_val), .fld_wild(fld_wild)
    );

    // Zero-extend each access field into its lane
    assign acc_lane = {MAXW'(acc_col), MAXW'(acc_page), MAXW'(acc_bank),
                       MAXW'(acc_chan), MAXW'(acc_rank), MAXW'(acc_dimm)};

    for (genvar g = 0; g < NUM_FLD; g++) begin : g_fld
        einj_field_match #(.MAXW(MAXW), .W(fld_w(g))) u_cmp (
            .cfg_val(fld_val[g*MAXW +: MAXW]),
            .wild(fld_wild[g]),
            .acc_val(acc_lane[g*MAXW +: MAXW]),
            .match(fld_hit[g])
        );
    end

    // Injecting access: armed write with every field matching
    assign hit = armed && acc_valid && acc_write && (&fld_hit);

    // Half-select expands to a per-bit enable
    assign half_mask = {{HALF{sect[1]}}, {HALF{sect[0]}}};

    // Registered injection outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inj_strobe <= 1'b0;
            inj_mask   <= '0;
            inj_parity <= 1'b0;
        end else begin
            inj_strobe <= hit;
            inj_mask   <= (hit && ecc_on) ? (ecc_mask & half_mask) : '0;
            inj_parity <= hit && par_on;
        end
    end

    // R6
    strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inj_strobe |-> $past(armed && acc_valid && acc_write));
    // R4
    no_read_inject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> !inj_strobe);
    // R8
    corrupt_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_parity || (|inj_mask)) |-> inj_strobe);
    // R7
    lower_half_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_strobe && !$past(sect[0])) |-> (inj_mask[HALF-1:0] == '0));
    // R7
    upper_half_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_strobe && !$past(sect[1])) |-> (inj_mask[ECC_W-1:HALF] == '0));
endmodule

// File: tb/sim_mem_err_inject.sv
`timescale 1ns/1ps
module sim_mem_err_inject;
    localparam int MAXW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_waddr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  cfg_raddr = '0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [1:0]  acc_dimm = '0, acc_rank = '0, acc_chan = '0;
    logic [2:0]  acc_bank = '0;
    logic [15:0] acc_page = '0;
    logic [10:0] acc_col = '0;
    logic        inj_strobe, inj_parity;
    logic [15:0] inj_mask;

    always #2 clk = ~clk;

    mem_err_inject u0 (.*);

    int total = 0, bad = 0, cyc = 0;
    bit mon_on = 0;

    typedef struct { int due; logic s; logic [15:0] m; logic p; string tag; } exp_t;
    exp_t q[$];

    // Bench-side register model
    logic [15:0] m_val [6];
    logic [5:0]  m_wild = '1;
    logic        m_armed = 0;
    logic [2:0]  m_type = 0;
    logic [1:0]  m_sect = 0;
    logic [15:0] m_ecc = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // Monitor: compare outputs each cycle with the due expectation
    always @(negedge clk) if (mon_on) begin
        exp_t e;
        e.due = cyc; e.s = 0; e.m = 0; e.p = 0; e.tag = "R6";
        if (q.size() > 0 && q[0].due == cyc) e = q.pop_front();
        chk(e.tag, {14'b0, inj_strobe, inj_mask, inj_parity}, {14'b0, e.s, e.m, e.p});
    end

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        acc_valid = 0; cfg_we = 1; cfg_waddr = a; cfg_wdata = d;
        case (a)
            4'h0: m_armed = |d;
            4'h1: m_type = d[2:0];
            4'h2: m_sect = d[1:0];
            4'h3: m_ecc = d[15:0];
            default: if (a >= 8 && a <= 13) begin
                m_val[a-8] = d[15:0]; m_wild[a-8] = d[31];
            end
        endcase
    endtask

    task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        cfg_we = 0; acc_valid = 0; cfg_raddr = a;
        #1 chk(tag, cfg_rdata, exp);
    endtask

    task automatic acc(logic w, int d, int r, int c, int b, int p, int col, string tag);
        exp_t e;
        int v [6];
        bit all;
        @(negedge clk);
        cfg_we = 0; acc_valid = 1; acc_write = w;
        acc_dimm = 2'(d); acc_rank = 2'(r); acc_chan = 2'(c);
        acc_bank = 3'(b); acc_page = 16'(p); acc_col = 11'(col);
        v[0] = d; v[1] = r; v[2] = c; v[3] = b; v[4] = p; v[5] = col;
        all = 1;
        for (int i = 0; i < 6; i++) if (!m_wild[i] && int'(m_val[i]) != v[i]) all = 0;
        e.due = cyc + 1; e.tag = tag;
        e.s = m_armed && w && all;
        e.m = (e.s && m_type[1]) ? (m_ecc & {{8{m_sect[1]}}, {8{m_sect[0]}}}) : 16'h0;
        e.p = e.s && m_type[2];
        if (e.s && !m_type[0]) m_armed = 0;
        q.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cfg_we = 0; acc_valid = 0;
        end
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 6; i++) m_val[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        chk("R1", {14'b0, inj_strobe, inj_mask, inj_parity}, 0);
        mon_on = 1;
        // R1 reset state of every register
        for (int i = 0; i < 6; i++) rd(4'(8 + i), 32'h8000_0000, "R1");
        rd(4'h0, 0, "R1"); rd(4'h1, 0, "R1"); rd(4'h2, 0, "R1"); rd(4'h3, 0, "R1");
        // R2 readback
        wr(4'h1, 32'h6); wr(4'h2, 32'h3); wr(4'h3, 32'hA5C3);
        wr(4'h8, 32'h0000_0002); wr(4'hD, 32'h8000_07FF);
        rd(4'h1, 32'h6, "R2"); rd(4'h2, 32'h3, "R2"); rd(4'h3, 32'hA5C3, "R2");
        rd(4'h8, 32'h0000_0002, "R2"); rd(4'hD, 32'h8000_07FF, "R2");
        // One-shot, lower half, channel match only
        wr(4'h8, 32'h8000_0000); wr(4'hD, 32'h8000_0000);
        wr(4'h1, 32'h2); wr(4'h2, 32'h1); wr(4'h3, 32'hFFFF);
        wr(4'hA, 32'h0000_0001);
        wr(4'h0, 32'h5);
        rd(4'h0, 32'h1, "R3");
        acc(0, 0, 0, 1, 0, 0, 0, "R4");        // read: no inject
        acc(1, 0, 0, 2, 0, 0, 0, "R4");        // channel mismatch
        acc(1, 3, 1, 1, 5, 77, 9, "R7");       // hit, lower half 0x00FF
        acc(1, 3, 1, 1, 5, 77, 9, "R9");       // already disarmed
        idle(2);
        rd(4'h0, 32'h0, "R9");
        // Repeat with parity, exact DIMM 0, upper half
        wr(4'hA, 32'h8000_0000); wr(4'h8, 32'h0000_0000);
        wr(4'h1, 32'h7); wr(4'h2, 32'h2); wr(4'h3, 32'h1234);
        wr(4'h0, 32'h1);
        acc(1, 0, 2, 3, 1, 10, 20, "R10");
        acc(1, 0, 1, 0, 7, 11, 21, "R10");
        acc(1, 0, 3, 2, 4, 12, 22, "R8");
        acc(1, 3, 0, 0, 0, 0, 0, "R5");        // DIMM 3 vs exact 0
        acc(1, 0, 0, 0, 0, 0, 0, "R5");
        idle(1);
        rd(4'h0, 32'h1, "R10");
        wr(4'h2, 32'h3);
        acc(1, 0, 0, 0, 0, 0, 0, "R7");        // both halves
        wr(4'h2, 32'h0);
        acc(1, 0, 0, 0, 0, 0, 0, "R7");        // no half
        wr(4'h1, 32'h1);
        acc(1, 0, 0, 0, 0, 0, 0, "R8");        // strobe only
        wr(4'h0, 32'h0);
        acc(1, 0, 0, 0, 0, 0, 0, "R3");        // disarmed
        idle(1);
        // All six fields exact
        wr(4'h8, 32'h2); wr(4'h9, 32'h1); wr(4'hA, 32'h3);
        wr(4'hB, 32'h5); wr(4'hC, 32'hBEEF); wr(4'hD, 32'h2A5);
        wr(4'h1, 32'h3); wr(4'h2, 32'h3); wr(4'h3, 32'h8001);
        wr(4'h0, 32'h80);
        acc(1, 2, 1, 3, 5, 16'hBEEF, 11'h2A4, "R4");
        acc(1, 2, 1, 3, 5, 16'hBEEF, 11'h2A5, "R4");
        acc(1, 2, 0, 3, 5, 16'hBEEF, 11'h2A5, "R5");
        idle(3);
        chk("R6", q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule